// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Controller

This block sits at the memory side of a shared word store and gives several requesters atomic read-modify-write through linked loads and conditional stores. Each requester carries a source ID. The controller keeps a table with one reservation per source. Each reservation is a valid bit and a word address.

A linked load reads a word and records a reservation for its source at that address. A conditional store from that source writes the word only if the reservation is still valid. Any store that reaches the address first removes the reservation. A spin-lock is built from a linked load, a conditional store of 1, and a retry while the store returns 0. The lock is released with a plain write of 0.

Requests arrive through a valid/ready handshake and are handled one at a time, in the order they are accepted. Each accepted request produces exactly one response on the following cycle.

Top module: `llsc_resv_ctrl`

## Requirements
- R1: After reset, no source holds a reservation, `req_ready` is 1, `rsp_valid` is 0 and every memory word reads 0.
- R2: `rsp_valid` is 1 on the cycle after a request is accepted (`req_valid` and `req_ready` both 1) and 0 otherwise. The response for each request comes before the response for any later request.
- R3: A READ (`req_cmd` = 2'b00) returns the stored word at `req_addr` in `rsp_data`. It neither creates nor removes any reservation.
- R4: A WRITE (`req_cmd` = 2'b01) stores `req_wdata` at `req_addr`, returns 0 and cancels every reservation held on that address by any source.
- R5: A LINKED_LOAD (`req_cmd` = 2'b10) returns the stored word at `req_addr` and records a valid reservation for (`req_src`, `req_addr`).
- R6: Each source holds at most one reservation. A linked load to a new address replaces that source's earlier reservation, so a conditional store to the old address then fails.
- R7: A STORE_CONDITIONAL (`req_cmd` = 2'b11) whose source holds a valid reservation on `req_addr` stores `req_wdata` and returns 1.
- R8: A successful conditional store cancels every reservation on its address, including those of other sources. Of several competing conditional stores to one address, only the first accepted succeeds.
- R9: A conditional store without a matching valid reservation returns 0 and leaves memory unchanged.
- R10: Reservations on other addresses are not affected by a write or a successful conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_cmd | input | 2 | 00 READ, 01 WRITE, 10 LINKED_LOAD, 11 STORE_CONDITIONAL |
| req_src | input | $clog2(NUM_SRC) | Source ID of the requester |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for WRITE and STORE_CONDITIONAL |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_data | output | DATA_W | Read data, 0 for WRITE, 1/0 for conditional store success/failure |

## Verification
The properties assume that `req_src` is below NUM_SRC whenever a request is accepted. With the default power-of-two source count, every ID is legal. They also assume that the request fields hold a known value while `req_valid` is high. The bench only issues requests from its request task. That task drives all fields together with `req_valid` on a falling edge and drops `req_valid` one cycle later, so every accepted beat is fully defined. Back-to-back acceptance is not exercised. The one-cycle response rule is checked instead on idle cycles between requests.

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_cmd,
  input  logic [$clog2(NUM_SRC)-1:0] req_src,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] CMD_RD = 2'b00, CMD_WR = 2'b01, CMD_LL = 2'b10, CMD_SC = 2'b11;

  logic [DATA_W-1:0]              mem [DEPTH];
  logic [NUM_SRC-1:0]             resv_vld;
  logic [NUM_SRC-1:0][ADDR_W-1:0] resv_addr;
  logic                           rdy_q;

  logic accept, sc_hit, do_store;
  logic [NUM_SRC-1:0] same_addr;

  assign req_ready = rdy_q;
  assign accept    = req_valid & rdy_q;
  assign sc_hit    = resv_vld[req_src] && (resv_addr[req_src] == req_addr);
  assign do_store  = accept && ((req_cmd == CMD_WR) || (req_cmd == CMD_SC && sc_hit));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
    assign same_addr[i] = resv_vld[i] && (resv_addr[i] == req_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_vld <= '0;
    end else if (accept) begin
      if (do_store) resv_vld <= resv_vld & ~same_addr;
      else if (req_cmd == CMD_LL) resv_vld[req_src] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_addr <= '0;
    end else if (accept && req_cmd == CMD_LL) begin
      resv_addr[req_src] <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (do_store) begin
      mem[req_addr] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        unique case (req_cmd)
          CMD_RD, CMD_LL: rsp_data <= mem[req_addr];
          CMD_WR:         rsp_data <= '0;
          default:        rsp_data <= {{(DATA_W-1){1'b0}}, sc_hit};
        endcase
      end
    end
  end

  logic unused_w;
  assign unused_w = ^SRC_W;
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [1:0]                 req_cmd,
  input logic [$clog2(NUM_SRC)-1:0] req_src,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       rsp_valid,
  input logic [DATA_W-1:0]          rsp_data,
  input logic [NUM_SRC-1:0]         resv_vld,
  input logic [NUM_SRC-1:0][ADDR_W-1:0] resv_addr
);
  logic acc;
  assign acc = req_valid & req_ready;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (resv_vld == '0 && !rsp_valid));

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid == $past(acc));

  // R3
  read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_cmd == 2'b00 |=> $stable(resv_vld) && $stable(resv_addr));

  // R5
  ll_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_cmd == 2'b10 |=> resv_vld[$past(req_src)] && resv_addr[$past(req_src)] == $past(req_addr));

  // R7
  sc_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_cmd) == 2'b11 |-> rsp_data <= 1);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // R8
    sc_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_cmd) == 2'b11 && rsp_data == 1
      |-> !(resv_vld[i] && resv_addr[i] == $past(req_addr)));
    // R4
    wr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_cmd == 2'b01 |=> !(resv_vld[i] && resv_addr[i] == $past(req_addr)));
  end
endmodule

bind llsc_resv_ctrl llsc_resv_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .req_src(req_src), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .resv_vld(resv_vld), .resv_addr(resv_addr)
);

// File: tb/llsc_resv_ctrl_tb.sv
module llsc_resv_ctrl_tb_top;
  localparam int NUM_SRC = 4, ADDR_W = 6, DATA_W = 32;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, LL = 2'b10, SC = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_ready, rsp_valid;
  logic [1:0] req_cmd = '0;
  logic [1:0] req_src = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rsp_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  llsc_resv_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] cmd, input logic [1:0] src, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_src = src; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid", {31'b0, rsp_valid}, 1);
    check(req, rsp_data, exp);
  endtask

  task automatic t_reset();
    check("R1 ready", {31'b0, req_ready}, 1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    xfer(SC, 2'd0, 6'd5, 32'h77, 0, "R1 R9 sc without ll");
    xfer(RD, 2'd1, 6'd5, 0, 0, "R9 memory unchanged");
  endtask

  task automatic t_rw();
    xfer(WR, 2'd0, 6'd3, 32'hA5, 0, "R4 write returns 0");
    xfer(RD, 2'd2, 6'd3, 0, 32'hA5, "R3 read back");
    @(negedge clk);
    check("R2 idle no response", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_ll_sc();
    xfer(LL, 2'd1, 6'd3, 0, 32'hA5, "R5 ll data");
    xfer(RD, 2'd2, 6'd3, 0, 32'hA5, "R3 read during reservation");
    xfer(SC, 2'd1, 6'd3, 32'h1, 1, "R7 sc success");
    xfer(RD, 2'd0, 6'd3, 0, 32'h1, "R7 sc stored");
  endtask

  task automatic t_compete();
    xfer(LL, 2'd0, 6'd8, 0, 0, "R5 ll src0");
    xfer(LL, 2'd2, 6'd8, 0, 0, "R5 ll src2");
    xfer(SC, 2'd2, 6'd8, 32'h22, 1, "R8 first sc wins");
    xfer(SC, 2'd0, 6'd8, 32'h11, 0, "R8 second sc fails");
    xfer(RD, 2'd3, 6'd8, 0, 32'h22, "R8 R9 winner value kept");
  endtask

  task automatic t_replace();
    xfer(LL, 2'd3, 6'd10, 0, 0, "R5 ll old addr");
    xfer(LL, 2'd3, 6'd11, 0, 0, "R6 ll new addr");
    xfer(SC, 2'd3, 6'd10, 32'h5, 0, "R6 old reservation gone");
    xfer(SC, 2'd3, 6'd11, 32'h6, 1, "R6 new reservation valid");
  endtask

  task automatic t_write_cancel();
    xfer(LL, 2'd1, 6'd12, 0, 0, "R5 ll src1");
    xfer(LL, 2'd2, 6'd13, 0, 0, "R5 ll src2");
    xfer(WR, 2'd3, 6'd12, 32'h9, 0, "R4 write");
    xfer(SC, 2'd1, 6'd12, 32'h4, 0, "R4 write cancelled reservation");
    xfer(SC, 2'd2, 6'd13, 32'h8, 1, "R10 other address kept");
    xfer(RD, 2'd0, 6'd12, 0, 32'h9, "R9 failed sc left memory");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_ll_sc();
    t_compete();
    t_replace();
    t_write_cancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule